// File: doc/BRIEF.md
# Aligned Return Address Stack

This block holds 12-bit return addresses in a small nibble-wide memory and tracks the top entry with an 8-bit return pointer. The memory is organised as four-nibble slots. A push advances the pointer by four and writes the 12-bit address into three nibbles of the slot it now points at. A pop moves the pointer back by four. The pointer always names the slot of the current top entry, and the block shows that entry on a 12-bit output without any extra cycle.

Nibble 0 of every slot is never touched by stack traffic. A separate nibble port can read any nibble of the memory, but it can write only these spare nibbles, so software can keep 4-bit variables between stacked addresses without harming them. After reset the pointer holds FCh, the value software is expected to load, and a load input can set it to any value at any time.

Top module: `rars_top`

## Requirements
- R1: After reset the pointer reads FCh, every memory nibble reads 0, and the top-entry output is 000h.
- R2: A push alone adds 4 to the pointer (modulo 256) and writes the address into nibbles 1, 2 and 3 of the slot named by the new pointer bits 7:2, low nibble in nibble 1 and high nibble in nibble 3.
- R3: A pop alone subtracts 4 from the pointer (modulo 256) and writes no memory nibble.
- R4: A pointer load sets the pointer to the load value, takes priority over push and pop in the same cycle, and writes no memory nibble.
- R5: A push and a pop in the same cycle, with no load, overwrite the entry in the current top slot and leave the pointer unchanged.
- R6: No push ever changes nibble 0 of any slot.
- R7: A nibble-port write to an address whose bits 1:0 are 00 stores the data there; the nibble port read returns the addressed nibble in the same cycle for any address.
- R8: A nibble-port write to an address whose bits 1:0 are not 00 changes nothing.
- R9: The pointer wraps: a push from FCh gives 00h and a pop from 00h gives FCh.
- R10: The top-entry output always equals nibbles 3, 2, 1 (high to low) of the slot named by pointer bits 7:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push the address on push_addr_i |
| push_addr_i | input | 12 | Address to push |
| pop_i | input | 1 | Pop the top entry |
| ptr_load_i | input | 1 | Load the pointer |
| ptr_load_val_i | input | 8 | Value to load into the pointer |
| ptr_o | output | 8 | Current return pointer |
| top_o | output | 12 | Current top-of-stack entry |
| var_we_i | input | 1 | Nibble port write enable |
| var_addr_i | input | 8 | Nibble port address |
| var_wdata_i | input | 4 | Nibble port write data |
| var_rdata_o | output | 4 | Nibble port read data |

## Verification
The assertions assume that control inputs are clean levels sampled once per clock and that a spare-nibble write may land in any slot, including the top one, in the same cycle as stack traffic. The stability checks on the top entry apply only in cycles with no push, pop or load, since only those cycles promise an unchanged entry. The stimulus keeps push and pop apart except in the cycles that test replacement and load priority, and it sweeps every slot and every nibble address of the memory so that the wrap and the spare-nibble protection are reached at each slot.

// File: rtl/rars_pkg.sv
package rars_pkg;
    localparam int unsigned PTR_W      = 8;
    localparam int unsigned NIB_W      = 4;
    localparam int unsigned ENTRY_NIBS = 3;
    localparam int unsigned ENTRY_W    = ENTRY_NIBS * NIB_W;
    localparam int unsigned SLOT_LSB   = 2;
    localparam int unsigned SLOT_W     = PTR_W - SLOT_LSB;
    localparam int unsigned DEPTH      = 1 << PTR_W;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PUSH,
        OP_POP,
        OP_REPLACE
    } stack_op_e;

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;
endpackage

// File: rtl/rars_ptr_ctrl.sv
module rars_ptr_ctrl
    import rars_pkg::*;
#(
    parameter logic [PTR_W-1:0] RESET_PTR = 8'hFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              load_i,
    input  logic [PTR_W-1:0]  load_val_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              entry_we_o,
    output logic [SLOT_W-1:0] entry_slot_o
);
    localparam logic [PTR_W-1:0] STEP = PTR_W'(1 << SLOT_LSB);

    ptr_state_t state_d, state_q;
    stack_op_e  op;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;

    always_comb begin
        op = OP_IDLE;
        if (!load_i) begin
            unique case ({push_i, pop_i})
                2'b10:   op = OP_PUSH;
                2'b01:   op = OP_POP;
                2'b11:   op = OP_REPLACE;
                default: op = OP_IDLE;
            endcase
        end
    end

    always_comb begin
        ptr_inc      = state_q.ptr + STEP;
        ptr_dec      = state_q.ptr - STEP;
        state_d      = state_q;
        entry_we_o   = 1'b0;
        entry_slot_o = state_q.ptr[PTR_W-1:SLOT_LSB];
        if (load_i) begin
            state_d.ptr = load_val_i;
        end else begin
            unique case (op)
                OP_PUSH: begin
                    state_d.ptr  = ptr_inc;
                    entry_we_o   = 1'b1;
                    entry_slot_o = ptr_inc[PTR_W-1:SLOT_LSB];
                end
                OP_POP: begin
                    state_d.ptr = ptr_dec;
                end
                OP_REPLACE: begin
                    entry_we_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.ptr <= RESET_PTR;
        end else begin
            state_q <= state_d;
        end
    end

    assign ptr_o = state_q.ptr;
endmodule

// File: rtl/rars_nibble_store.sv
module rars_nibble_store
    import rars_pkg::*;
#(
    parameter int unsigned SPARE_IDX = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               entry_we_i,
    input  logic [SLOT_W-1:0]  entry_slot_i,
    input  logic [ENTRY_W-1:0] entry_data_i,
    input  logic               var_we_i,
    input  logic [PTR_W-1:0]   var_addr_i,
    input  logic [NIB_W-1:0]   var_wdata_i,
    input  logic [SLOT_W-1:0]  top_slot_i,
    output logic [ENTRY_W-1:0] top_data_o,
    output logic [NIB_W-1:0]   var_rdata_o
);
    localparam int unsigned SLOT_NIBS = 1 << SLOT_LSB;

    logic [DEPTH-1:0][NIB_W-1:0] mem_d, mem_q;
    logic                        var_ok;

    assign var_ok = var_we_i &&
        (var_addr_i[SLOT_LSB-1:0] == SLOT_LSB'(SPARE_IDX));

    always_comb begin
        mem_d = mem_q;
        if (var_ok) begin
            mem_d[var_addr_i] = var_wdata_i;
        end
        if (entry_we_i) begin
            for (int k = 0; k < ENTRY_NIBS; k++) begin
                mem_d[{entry_slot_i, SLOT_LSB'((SPARE_IDX + 1 + k) % SLOT_NIBS)}] =
                    entry_data_i[k*NIB_W +: NIB_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    genvar g;
    generate
        for (g = 0; g < ENTRY_NIBS; g++) begin : g_top_read
            assign top_data_o[g*NIB_W +: NIB_W] =
                mem_q[{top_slot_i, SLOT_LSB'((SPARE_IDX + 1 + g) % SLOT_NIBS)}];
        end
    endgenerate

    assign var_rdata_o = mem_q[var_addr_i];
endmodule

// File: rtl/rars_top.sv
module rars_top
    import rars_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [ENTRY_W-1:0] push_addr_i,
    input  logic               pop_i,
    input  logic               ptr_load_i,
    input  logic [PTR_W-1:0]   ptr_load_val_i,
    output logic [PTR_W-1:0]   ptr_o,
    output logic [ENTRY_W-1:0] top_o,
    input  logic               var_we_i,
    input  logic [PTR_W-1:0]   var_addr_i,
    input  logic [NIB_W-1:0]   var_wdata_i,
    output logic [NIB_W-1:0]   var_rdata_o
);
    logic              entry_we;
    logic [SLOT_W-1:0] entry_slot;

    rars_ptr_ctrl #(
        .RESET_PTR (8'hFC)
    ) i_ptr (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push_i),
        .pop_i        (pop_i),
        .load_i       (ptr_load_i),
        .load_val_i   (ptr_load_val_i),
        .ptr_o        (ptr_o),
        .entry_we_o   (entry_we),
        .entry_slot_o (entry_slot)
    );

    rars_nibble_store #(
        .SPARE_IDX (0)
    ) i_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .entry_we_i   (entry_we),
        .entry_slot_i (entry_slot),
        .entry_data_i (push_addr_i),
        .var_we_i     (var_we_i),
        .var_addr_i   (var_addr_i),
        .var_wdata_i  (var_wdata_i),
        .top_slot_i   (ptr_o[PTR_W-1:SLOT_LSB]),
        .top_data_o   (top_o),
        .var_rdata_o  (var_rdata_o)
    );
endmodule

// File: rtl/rars_checker.sv
module rars_checker
    import rars_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               push_i,
    input logic [ENTRY_W-1:0] push_addr_i,
    input logic               pop_i,
    input logic               ptr_load_i,
    input logic [PTR_W-1:0]   ptr_load_val_i,
    input logic [PTR_W-1:0]   ptr_o,
    input logic [ENTRY_W-1:0] top_o,
    input logic               var_we_i
);
    logic quiet;
    assign quiet = !push_i && !pop_i && !ptr_load_i;

    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !ptr_load_i) |=> (ptr_o == $past(ptr_o) + 8'd4));

    assert_push_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !ptr_load_i) |=> (top_o == $past(push_addr_i)));

    assert_pop_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !ptr_load_i) |=> (ptr_o == $past(ptr_o) - 8'd4));

    assert_load_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load_i |=> (ptr_o == $past(ptr_load_val_i)));

    assert_replace_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !ptr_load_i) |=> $stable(ptr_o));

    assert_spare_safe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && var_we_i) |=> $stable(top_o));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> ($stable(ptr_o) && $stable(top_o)));
endmodule

bind rars_top rars_checker i_rars_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .push_i         (push_i),
    .push_addr_i    (push_addr_i),
    .pop_i          (pop_i),
    .ptr_load_i     (ptr_load_i),
    .ptr_load_val_i (ptr_load_val_i),
    .ptr_o          (ptr_o),
    .top_o          (top_o),
    .var_we_i       (var_we_i)
);

// File: tb/test_rars_top.sv
module test_rars_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic [11:0] push_addr_i = '0;
    logic        pop_i = 1'b0;
    logic        ptr_load_i = 1'b0;
    logic [7:0]  ptr_load_val_i = '0;
    logic [7:0]  ptr_o;
    logic [11:0] top_o;
    logic        var_we_i = 1'b0;
    logic [7:0]  var_addr_i = '0;
    logic [3:0]  var_wdata_i = '0;
    logic [3:0]  var_rdata_o;

    int checks = 0;
    int fails  = 0;
    logic [3:0] model [256];
    logic [7:0] mptr;

    always #5 clk = ~clk;

    rars_top i_rars_top (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
        .pop_i(pop_i), .ptr_load_i(ptr_load_i), .ptr_load_val_i(ptr_load_val_i),
        .ptr_o(ptr_o), .top_o(top_o), .var_we_i(var_we_i), .var_addr_i(var_addr_i),
        .var_wdata_i(var_wdata_i), .var_rdata_o(var_rdata_o)
    );

    function automatic logic [11:0] entry_val(int k);
        return 12'((k * 12'h1A7) ^ 12'h5C3);
    endfunction

    function automatic logic [11:0] model_top();
        logic [7:0] b;
        b = {mptr[7:2], 2'b00};
        return {model[b + 3], model[b + 2], model[b + 1]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        push_i = 0; pop_i = 0; ptr_load_i = 0; var_we_i = 0;
    endtask

    task automatic do_push(logic [11:0] a);
        push_i = 1; push_addr_i = a;
        tick();
        mptr = mptr + 8'd4;
        model[{mptr[7:2], 2'b01}] = a[3:0];
        model[{mptr[7:2], 2'b10}] = a[7:4];
        model[{mptr[7:2], 2'b11}] = a[11:8];
    endtask

    task automatic do_pop();
        pop_i = 1;
        tick();
        mptr = mptr - 8'd4;
    endtask

    task automatic sweep_mem(string req);
        for (int a = 0; a < 256; a++) begin
            var_addr_i = 8'(a);
            #1;
            check(req, 32'(var_rdata_o), 32'(model[a]));
        end
    endtask

    initial begin
        #200000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) model[a] = 4'h0;
        mptr = 8'hFC;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        check("R1 ptr", 32'(ptr_o), 32'h0FC);
        check("R1 top", 32'(top_o), 32'h000);
        sweep_mem("R1 mem");

        // R2 / R9 / R10 push every slot; first push wraps FCh -> 00h
        for (int k = 0; k < 64; k++) begin
            do_push(entry_val(k));
            check("R2 ptr", 32'(ptr_o), 32'(mptr));
            check("R10 top", 32'(top_o), 32'(model_top()));
            if (k == 0) check("R9 push wrap", 32'(ptr_o), 32'h000);
        end
        // R6 spare nibbles untouched, entries placed low nibble first
        sweep_mem("R6 R2 layout");

        // R7 spare writes in every slot, with stable top
        for (int s = 0; s < 64; s++) begin
            var_we_i = 1; var_addr_i = {6'(s), 2'b00}; var_wdata_i = 4'(s) ^ 4'hA;
            tick();
            model[{6'(s), 2'b00}] = 4'(s) ^ 4'hA;
            check("R7 top stable", 32'(top_o), 32'(model_top()));
        end
        sweep_mem("R7 readback");

        // R8 writes at entry nibbles are ignored
        for (int a = 0; a < 256; a++) begin
            if (a[1:0] != 2'b00) begin
                var_we_i = 1; var_addr_i = 8'(a); var_wdata_i = ~model[a];
                tick();
            end
        end
        check("R8 top", 32'(top_o), 32'(model_top()));
        sweep_mem("R8 memory");

        // R3 / R9 pop through every slot; last pop wraps 00h -> FCh
        for (int k = 0; k < 64; k++) begin
            do_pop();
            check("R3 ptr", 32'(ptr_o), 32'(mptr));
            check("R10 top", 32'(top_o), 32'(model_top()));
            if (k == 62) check("R9 at zero", 32'(ptr_o), 32'h000);
            if (k == 63) check("R9 pop wrap", 32'(ptr_o), 32'h0FC);
        end
        sweep_mem("R3 no write");

        // R4 load with push and pop held high
        ptr_load_i = 1; ptr_load_val_i = 8'h41; push_i = 1; pop_i = 1;
        push_addr_i = 12'hBAD;
        tick();
        mptr = 8'h41;
        check("R4 ptr", 32'(ptr_o), 32'h041);
        check("R4 top", 32'(top_o), 32'(model_top()));
        sweep_mem("R4 no write");

        // R5 replace top, pointer unchanged (low bits 01 kept)
        push_i = 1; pop_i = 1; push_addr_i = 12'h9E7;
        tick();
        model[{mptr[7:2], 2'b01}] = 4'h7;
        model[{mptr[7:2], 2'b10}] = 4'hE;
        model[{mptr[7:2], 2'b11}] = 4'h9;
        check("R5 ptr", 32'(ptr_o), 32'h041);
        check("R5 top", 32'(top_o), 32'h9E7);
        sweep_mem("R5 memory");

        // R2 push from unaligned pointer keeps low bits
        do_push(12'h123);
        check("R2 unaligned ptr", 32'(ptr_o), 32'h045);
        check("R2 unaligned top", 32'(top_o), 32'h123);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule